// File: doc/BRIEF.md
# Event Interrupt Priority Vector Unit

This block collects interrupt requests from up to sixteen event channels. Each channel sends a one-cycle set pulse, which latches into a pending register. A mask register selects which pending sources may raise the single summary interrupt. Software reads a priority vector register to find the most urgent pending, unmasked source. That same read also clears the pending bit of the source it reports, so an interrupt handler can loop on the vector until it reads zero.

The register port is a simple one. A 2-bit address selects a register, and there is a write strobe and a read strobe. The read data is combinational: it reflects the selected register whenever that address is presented. The read strobe matters only for the vector register, because only that read has a side effect.

The address map is:
- 0 is the mask register.
- 1 is the pending register.
- 2 is the vector register.
- 3 reads as zero.

Top module: `evp_unit`

## Requirements
- R1: After reset the mask and pending registers read 0, the vector reads 0 and `irq_o` is low.
- R2: A set pulse on `src_set[i]` for an implemented bit i makes pending bit i read 1 from the next clock edge on.
- R3: Bits 2, 3, 4, 5, 14 and 15 are reserved. In both the mask and the pending registers they always read 0. Neither set pulses nor register writes can set them.
- R4: The vector register (address 2) returns i+1 in bits 4:0, where i is the lowest-numbered bit set in both pending and mask. It returns 0 when no such bit exists. Bits 15:5 always read 0.
- R5: A vector read (`reg_rd` high, address 2) clears the pending bit it reports at the next clock edge. All other pending bits are left unchanged.
- R6: If a set pulse for bit i arrives in the same cycle as a vector read that clears bit i, bit i stays set.
- R7: `irq_o` is high exactly while some bit is set in both pending and mask. It stays high until every such bit has been cleared.
- R8: A write to address 1 loads the implemented pending bits from `reg_wdata`. A set pulse on a bit in the same cycle overrides the written value to 1.
- R9: A write to address 0 loads the implemented mask bits. A pending bit whose mask bit is 0 is never reported by the vector and never cleared by a vector read.
- R10: A vector read that returns 0 leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_set | input | 16 | One-cycle set pulses, one per event channel |
| reg_addr | input | 2 | Register select: 0 mask, 1 pending, 2 vector |
| reg_wr | input | 1 | Write strobe for the mask or pending register |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe; clears the serviced bit when the vector is read |
| reg_rdata | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Summary interrupt request |

## Verification
The hardest situation to reach is a set pulse on a channel that lands in the very cycle in which a vector read is clearing that same channel. The port alone gives no sign that the two met. The stimulus first loads a single known pending bit with a register write. It then drives the set pulse and the vector read in one cycle, and reads the pending register afterwards to confirm the bit survived. A second hard case is a set pulse arriving during a software write to the pending register. It is reached the same way, by pairing the pulse with a pending write in one cycle.

// File: rtl/evp_pkg.sv
package evp_pkg;

   typedef enum logic [1:0] {
      EVP_A_MASK = 2'd0,
      EVP_A_PEND = 2'd1,
      EVP_A_VEC  = 2'd2,
      EVP_A_NONE = 2'd3
   } evp_addr_e;

   localparam logic [15:0] EVP_DEF_RSVD = 16'hC03C;

endpackage

// File: rtl/evp_pend_cell.sv
module evp_pend_cell #(
   parameter bit IMPL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic wr_en_i,
   input  logic wr_val_i,
   output logic q_o
);
   generate
      if (IMPL) begin : g_impl
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q_r <= 1'b0;
            else if (set_i)   q_r <= 1'b1;
            else if (wr_en_i) q_r <= wr_val_i;
            else if (clr_i)   q_r <= 1'b0;
         end
         assign q_o = q_r;

         AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o); // R2
         AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i && !wr_en_i) |=> !q_o); // R5
      end else begin : g_rsvd
         logic unused_in;
         assign unused_in = ^{clk, rst_n, set_i, clr_i, wr_en_i, wr_val_i};
         assign q_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/evp_mask_reg.sv
module evp_mask_reg #(
   parameter int          NUM_SRC  = 16,
   parameter logic [15:0] RSVD_MAP = 16'hC03C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [NUM_SRC-1:0] wr_val_i,
   output logic [NUM_SRC-1:0] mask_o
);
   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      if (!RSVD_MAP[b]) begin : g_impl
         logic m_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       m_r <= 1'b0;
            else if (wr_en_i) m_r <= wr_val_i[b];
         end
         assign mask_o[b] = m_r;
      end else begin : g_rsvd
         logic unused_w;
         assign unused_w = wr_val_i[b];
         assign mask_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/evp_prio_enc.sv
module evp_prio_enc #(
   parameter int NUM_SRC = 16,
   parameter int CODE_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   output logic [CODE_W-1:0]  code_o,
   output logic [NUM_SRC-1:0] grant_o
);
   always_comb begin
      code_o  = '0;
      grant_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            code_o  = CODE_W'(i + 1);
            grant_o = '0;
            grant_o[i] = 1'b1;
         end
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R4
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      code_o <= CODE_W'(NUM_SRC)); // R4
endmodule

// File: rtl/evp_regport.sv
module evp_regport
   import evp_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int CODE_W  = 5,
   parameter int DATA_W  = 16
) (
   input  logic [1:0]         addr_i,
   input  logic               wr_i,
   input  logic               rd_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [CODE_W-1:0]  code_i,
   output logic               wr_mask_o,
   output logic               wr_pend_o,
   output logic               rd_vec_o,
   output logic [DATA_W-1:0]  rdata_o
);
   evp_addr_e sel;
   assign sel       = evp_addr_e'(addr_i);
   assign wr_mask_o = wr_i && (sel == EVP_A_MASK);
   assign wr_pend_o = wr_i && (sel == EVP_A_PEND);
   assign rd_vec_o  = rd_i && (sel == EVP_A_VEC);

   always_comb begin
      unique case (sel)
         EVP_A_MASK: rdata_o = DATA_W'(mask_i);
         EVP_A_PEND: rdata_o = DATA_W'(pend_i);
         EVP_A_VEC:  rdata_o = DATA_W'(code_i);
         default:    rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/evp_unit.sv
module evp_unit
   import evp_pkg::*;
#(
   parameter int          NUM_SRC  = 16,
   parameter int          DATA_W   = 16,
   parameter logic [15:0] RSVD_MAP = EVP_DEF_RSVD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_set,
   input  logic [1:0]         reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_rd,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_o
);
   localparam int CODE_W = 5;

   if (NUM_SRC < 1 || NUM_SRC > 16) begin : g_bad_num
      $error("evp_unit: NUM_SRC must be 1..16");
   end
   if (DATA_W < NUM_SRC) begin : g_bad_data
      $error("evp_unit: DATA_W must cover NUM_SRC");
   end

   logic [NUM_SRC-1:0] mask_q, pend_q, grant, clr_vec;
   logic [CODE_W-1:0]  enc_code;
   logic               wr_mask, wr_pend, rd_vec;

   evp_regport #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_port (
      .addr_i(reg_addr), .wr_i(reg_wr), .rd_i(reg_rd),
      .mask_i(mask_q), .pend_i(pend_q), .code_i(enc_code),
      .wr_mask_o(wr_mask), .wr_pend_o(wr_pend), .rd_vec_o(rd_vec),
      .rdata_o(reg_rdata)
   );

   evp_mask_reg #(.NUM_SRC(NUM_SRC), .RSVD_MAP(RSVD_MAP)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_mask),
      .wr_val_i(reg_wdata[NUM_SRC-1:0]), .mask_o(mask_q)
   );

   assign clr_vec = grant & {NUM_SRC{rd_vec}};

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_pend
      evp_pend_cell #(.IMPL(!RSVD_MAP[b])) u_cell (
         .clk(clk), .rst_n(rst_n), .set_i(src_set[b]), .clr_i(clr_vec[b]),
         .wr_en_i(wr_pend), .wr_val_i(reg_wdata[b]), .q_o(pend_q[b])
      );
   end

   evp_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .req_i(pend_q & mask_q),
      .code_o(enc_code), .grant_o(grant)
   );

   assign irq_o = |(pend_q & mask_q);

   AST_IRQ_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (enc_code != '0)); // R7
   AST_EMPTY_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vec && enc_code == '0 && src_set == '0 && !reg_wr) |=> $stable(pend_q)); // R10
endmodule

// File: tb/evp_unit_tb.sv
module evp_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_set = '0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_rdata;
   logic        irq_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   localparam logic [15:0] IMPL = 16'h3FC3;

   always #10 clk = ~clk;

   evp_unit dut_i (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         total++; bad++;
         $display("FAIL watchdog: act=%0d exp<=5000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic op(input logic [15:0] set, input logic [1:0] a, input logic wr,
                     input logic [15:0] wd, input logic rd, output logic [15:0] rv);
      @(negedge clk);
      src_set = set; reg_addr = a; reg_wr = wr; reg_wdata = wd; reg_rd = rd;
      #5 rv = reg_rdata;
      @(posedge clk); #1;
      src_set = '0; reg_wr = 1'b0; reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b0;
      #5 v = reg_rdata;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [15:0] d);
      logic [15:0] dummy;
      op('0, a, 1'b1, d, 1'b0, dummy);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      peek(2'd0, v); chk("R1 mask", v, 16'h0);
      peek(2'd1, v); chk("R1 pend", v, 16'h0);
      peek(2'd2, v); chk("R1 vec", v, 16'h0);
      chk("R1 irq", {15'b0, irq_o}, 16'h0);
   endtask

   task automatic t_set;
      logic [15:0] v;
      op(16'h2081, 2'd3, 1'b0, '0, 1'b0, v);
      peek(2'd1, v); chk("R2 set pulses", v, 16'h2081);
      chk("R7 irq masked off", {15'b0, irq_o}, 16'h0);
      wreg(2'd1, 16'h0);
   endtask

   task automatic t_reserved;
      logic [15:0] v;
      op(16'hFFFF, 2'd3, 1'b0, '0, 1'b0, v);
      peek(2'd1, v); chk("R3 pend via pulse", v, IMPL);
      wreg(2'd1, 16'h0);
      wreg(2'd1, 16'hFFFF);
      peek(2'd1, v); chk("R3 pend via write", v, IMPL);
      wreg(2'd0, 16'hFFFF);
      peek(2'd0, v); chk("R3 mask via write", v, IMPL);
      wreg(2'd1, 16'h0);
   endtask

   task automatic t_priority;
      logic [15:0] v;
      wreg(2'd1, 16'h3FC0);
      peek(2'd2, v); chk("R4 vec bit6", v, 16'd7);
      chk("R7 irq", {15'b0, irq_o}, 16'h1);
      op(16'h0002, 2'd3, 1'b0, '0, 1'b0, v);
      peek(2'd2, v); chk("R4 vec bit1", v, 16'd2);
      op(16'h0001, 2'd3, 1'b0, '0, 1'b0, v);
      peek(2'd2, v); chk("R4 vec bit0", v, 16'd1);
      wreg(2'd1, 16'h2000);
      peek(2'd2, v); chk("R4 vec bit13", v, 16'd14);
      chk("R4 upper zero", v & 16'hFFE0, 16'h0);
   endtask

   task automatic t_readclear;
      logic [15:0] v;
      logic [15:0] exp_p;
      wreg(2'd1, 16'h3FC3);
      exp_p = 16'h3FC3;
      for (int i = 0; i < 16; i++) begin
         if (exp_p[i]) begin
            chk("R7 irq held", {15'b0, irq_o}, 16'h1);
            op('0, 2'd2, 1'b0, '0, 1'b1, v);
            chk("R5 read code", v, 16'(i + 1));
            exp_p[i] = 1'b0;
            peek(2'd1, v); chk("R5 pend after read", v, exp_p);
         end
      end
      chk("R7 irq drops", {15'b0, irq_o}, 16'h0);
   endtask

   task automatic t_collide;
      logic [15:0] v;
      wreg(2'd1, 16'h0040);
      op(16'h0040, 2'd2, 1'b0, '0, 1'b1, v);
      chk("R6 read code", v, 16'd7);
      peek(2'd1, v); chk("R6 bit survives", v, 16'h0040);
      chk("R6 irq", {15'b0, irq_o}, 16'h1);
      wreg(2'd1, 16'h0);
   endtask

   task automatic t_swwrite;
      logic [15:0] v;
      wreg(2'd1, 16'h0003);
      peek(2'd1, v); chk("R8 write", v, 16'h0003);
      op(16'h0002, 2'd1, 1'b1, 16'h0001, 1'b0, v);
      peek(2'd1, v); chk("R8 set beats write", v, 16'h0003);
      wreg(2'd1, 16'h0);
      peek(2'd1, v); chk("R8 write clear", v, 16'h0);
   endtask

   task automatic t_mask;
      logic [15:0] v;
      wreg(2'd0, 16'h0100);
      wreg(2'd1, 16'h0103);
      peek(2'd2, v); chk("R9 vec masked", v, 16'd9);
      op('0, 2'd2, 1'b0, '0, 1'b1, v);
      chk("R9 read code", v, 16'd9);
      peek(2'd1, v); chk("R9 masked kept", v, 16'h0003);
      chk("R9 irq", {15'b0, irq_o}, 16'h0);
      op('0, 2'd2, 1'b0, '0, 1'b1, v);
      chk("R10 empty read", v, 16'h0);
      peek(2'd1, v); chk("R10 pend unchanged", v, 16'h0003);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_set();
      t_reserved();
      t_priority();
      t_readclear();
      t_collide();
      t_swwrite();
      t_mask();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule